// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that finishes one instruction in every clock cycle. It runs seven instructions: register add and subtract, OR with an immediate, word load, word store, branch on equal, and an absolute jump. The core fetches from a small internal instruction array and decodes the fetched word into control signals. It reads two operands from a 32-entry register file, runs them through an ALU, and accesses an internal data array. At the clock edge that closes the cycle it commits the register or memory write and the new program counter.

A loading port fills both arrays before the core runs, and it can also fill them while the core is paused. The core holds still for every cycle in which the port is in use. A combinational debug port reads any register, so a surrounding environment can watch what the program does.

Top module: `mini_sc_cpu`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears all 32 registers at the next rising edge.
- R2: An instruction with opcode bits [31:26] = 000000 writes register rd (bits [15:11]) with rs + rt when funct bits [5:0] = 100000, and with rs - rt when funct = 100010. rs is bits [25:21] and rt is bits [20:16]. Both results wrap modulo 2^32, and the PC then advances by 4.
- R3: Opcode 001101 writes register rt with rs OR the zero-extended 16-bit immediate in bits [15:0].
- R4: Opcode 100011 writes register rt with the data word at byte address rs + sign-extended immediate. The word is selected by address bits [N+1:2], where N is the data array's index width.
- R5: Opcode 101011 writes register rt into the data word at rs + sign-extended immediate and leaves every register unchanged.
- R6: Opcode 000100 compares rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended immediate × 4); otherwise it is PC + 4. Neither registers nor data memory are written.
- R7: Opcode 000010 loads the PC with {PC[31:28], bits [25:0], 2'b00}.
- R8: Register 0 always reads as 0, and writes that name it as the destination are discarded.
- R9: Any other opcode, and any opcode-000000 word with a funct other than the two in R2, writes nothing and advances the PC by 4.
- R10: While `load_en` is 1, the core holds its PC and makes no register or data-memory write. The port writes `load_data` into word `load_addr` of the instruction array when `load_sel` = 0, and of the data array when `load_sel` = 1.
- R11: `dbg_data` shows register `dbg_idx` combinationally, with no clock edge between a change of `dbg_idx` and the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Loading port write strobe; pauses the core |
| load_sel | input | 1 | Array select: 0 instruction, 1 data |
| load_addr | input | 6 | Word index for the loading port |
| load_data | input | 32 | Word written by the loading port |
| dbg_idx | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_idx` |
| pc | output | 32 | Current program counter |

## Verification
The assertions take for granted that instructions and data are loaded before they are used. They also assume the core is released from reset only when the instruction word at PC 0 is defined, so that the decoded controls are never unknown. The bench meets these assumptions by loading every instruction word and every data word a load touches while reset is still held. Its programs only branch or jump to slots it has filled, and a self-loop at the end keeps the PC inside loaded code. The loading port is raised only while the PC sits on a filled slot, so the pause and the resumption both execute known words.

// File: rtl/cpu_pkg.sv
`timescale 1ns/1ps
package cpu_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JUMP  = 6'b000010;
    localparam logic [5:0] FN_ADD   = 6'b100000;
    localparam logic [5:0] FN_SUB   = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    wb_from_mem;
        logic    reg_wr;
        logic    mem_wr;
        logic    branch;
        logic    jump;
        logic    imm_signed;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/ctrl_dec.sv
`timescale 1ns/1ps
module ctrl_dec
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    logic is_r, is_add, is_sub, is_ori, is_lw, is_sw, is_beq, is_jmp;

    // product terms
    always_comb begin
        is_r   = (opcode == OP_RTYPE);
        is_add = is_r && (funct == FN_ADD);
        is_sub = is_r && (funct == FN_SUB);
        is_ori = (opcode == OP_ORI);
        is_lw  = (opcode == OP_LW);
        is_sw  = (opcode == OP_SW);
        is_beq = (opcode == OP_BEQ);
        is_jmp = (opcode == OP_JUMP);
    end

    // sum terms; an unmatched word leaves every enable at 0 (R9)
    always_comb begin
        ctl.dst_is_rd   = is_add | is_sub;
        ctl.b_is_imm    = is_ori | is_lw | is_sw;
        ctl.wb_from_mem = is_lw;
        ctl.reg_wr      = is_add | is_sub | is_ori | is_lw;
        ctl.mem_wr      = is_sw;
        ctl.branch      = is_beq;
        ctl.jump        = is_jmp;
        ctl.imm_signed  = is_lw | is_sw;
        ctl.alu_op      = alu_op_e'({is_ori, is_sub | is_beq});
    end
endmodule

// File: rtl/reg_file.sv
`timescale 1ns/1ps
module reg_file #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int IW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    wa,
    input  logic [WIDTH-1:0] wd,
    input  logic [IW-1:0]    ra_a,
    output logic [WIDTH-1:0] rd_a,
    input  logic [IW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_b,
    input  logic [IW-1:0]    ra_dbg,
    output logic [WIDTH-1:0] rd_dbg
);
    logic [WIDTH-1:0] regs_q [NREG];

    // R1 reset clear, R8 register 0 never written
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    function automatic logic [WIDTH-1:0] rd_port(input logic [IW-1:0] a);
        return (a == '0) ? '0 : regs_q[a];
    endfunction

    // combinational reads (R11)
    always_comb begin
        rd_a   = rd_port(ra_a);
        rd_b   = rd_port(ra_b);
        rd_dbg = rd_port(ra_dbg);
    end
endmodule

// File: rtl/alu.sv
`timescale 1ns/1ps
module alu
    import cpu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] y,
    output logic             zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mini_sc_cpu.sv
`timescale 1ns/1ps
module mini_sc_cpu
    import cpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic            load_sel,
    input  logic [LAW-1:0]  load_addr,
    input  logic [31:0]     load_data,
    input  logic [4:0]      dbg_idx,
    output logic [31:0]     dbg_data,
    output logic [31:0]     pc
);
    core_state_t core_d, core_q;

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] instr;
    ctrl_t       ctl;
    logic [31:0] rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rd, wb_val;
    logic [4:0]  wb_idx;
    logic        zero;
    logic        run;
    logic [31:0] pc_seq, pc_br, pc_jmp, pc_next;

    assign run   = !load_en && !rst;
    assign instr = imem[core_q.pc[IAW+1:2]];
    assign pc    = core_q.pc;

    ctrl_dec u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    reg_file #(.NREG(32), .WIDTH(32)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (ctl.reg_wr && run),
        .wa     (wb_idx),
        .wd     (wb_val),
        .ra_a   (instr[25:21]),
        .rd_a   (rs_val),
        .ra_b   (instr[20:16]),
        .rd_b   (rt_val),
        .ra_dbg (dbg_idx),
        .rd_dbg (dbg_data)
    );

    // extender and operand select
    always_comb begin
        imm_ext = ctl.imm_signed ? {{16{instr[15]}}, instr[15:0]}
                                 : {16'b0, instr[15:0]};
        alu_b   = ctl.b_is_imm ? imm_ext : rt_val;
    end

    alu #(.WIDTH(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (zero)
    );

    // write-back path
    always_comb begin
        mem_rd = dmem[alu_y[DAW+1:2]];
        wb_val = ctl.wb_from_mem ? mem_rd : alu_y;
        wb_idx = ctl.dst_is_rd ? instr[15:11] : instr[20:16];
    end

    // next PC
    always_comb begin
        pc_seq = core_q.pc + 32'd4;
        pc_br  = pc_seq + {{14{instr[15]}}, instr[15:0], 2'b00};
        pc_jmp = {core_q.pc[31:28], instr[25:0], 2'b00};
        if (ctl.jump)                 pc_next = pc_jmp;
        else if (ctl.branch && zero)  pc_next = pc_br;
        else                          pc_next = pc_seq;
    end

    always_comb begin
        core_d = core_q;
        if (!load_en) core_d.pc = pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    // instruction array: written only by the loading port
    always_ff @(posedge clk) begin
        if (load_en && !load_sel) imem[load_addr[IAW-1:0]] <= load_data;
    end

    // data array: loading port has priority, core stores otherwise
    always_ff @(posedge clk) begin
        if (load_en && load_sel)        dmem[load_addr[DAW-1:0]] <= load_data;
        else if (run && ctl.mem_wr)     dmem[alu_y[DAW+1:2]] <= rt_val;
    end
endmodule

// File: rtl/mini_sc_cpu_chk.sv
`timescale 1ns/1ps
module mini_sc_cpu_chk
    import cpu_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         load_en,
    input logic [31:0]  pc,
    input logic [31:0]  instr,
    input ctrl_t        ctl,
    input logic         zero,
    input logic [4:0]   dbg_idx,
    input logic [31:0]  dbg_data
);
    logic known;
    always_comb begin
        known = ((instr[31:26] == OP_RTYPE) &&
                 ((instr[5:0] == FN_ADD) || (instr[5:0] == FN_SUB))) ||
                (instr[31:26] == OP_ORI) || (instr[31:26] == OP_LW) ||
                (instr[31:26] == OP_SW)  || (instr[31:26] == OP_BEQ) ||
                (instr[31:26] == OP_JUMP);
    end

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == 32'd0));

    // R10
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (pc == $past(pc)));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && ctl.jump) |=>
            (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    // R6
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && ctl.branch && !zero) |=> (pc == $past(pc) + 32'd4));

    // R5
    store_no_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OP_SW) |-> (ctl.mem_wr && !ctl.reg_wr));

    // R9
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!ctl.reg_wr && !ctl.mem_wr && !ctl.branch && !ctl.jump));

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx == 5'd0) |-> (dbg_data == 32'd0));
endmodule

bind mini_sc_cpu mini_sc_cpu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .pc       (pc),
    .instr    (instr),
    .ctl      (ctl),
    .zero     (zero),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data)
);

// File: tb/sim_mini_sc_cpu.sv
`timescale 1ns/1ps
module sim_mini_sc_cpu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_sel = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_idx = '0;
    logic [31:0] dbg_data;
    logic [31:0] pc;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mini_sc_cpu u0 (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
        .load_addr(load_addr), .load_data(load_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .pc(pc)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [4:0]  rsel;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{enc_i(6'h0D, 5'd0, 5'd1, 16'h1234), 5'd1,  32'h0000_1234, 4'd3}, // R3
        '{enc_i(6'h0D, 5'd0, 5'd2, 16'hFFFF), 5'd2,  32'h0000_FFFF, 4'd3}, // R3 zero-extend
        '{enc_r(5'd1, 5'd2, 5'd3, 6'h20),     5'd3,  32'h0001_1233, 4'd2}, // R2 add
        '{enc_r(5'd1, 5'd2, 5'd4, 6'h22),     5'd4,  32'hFFFF_1235, 4'd2}, // R2 sub wraps
        '{enc_i(6'h2B, 5'd0, 5'd3, 16'h0008), 5'd3,  32'h0001_1233, 4'd5}, // R5 rt untouched
        '{enc_i(6'h23, 5'd0, 5'd5, 16'h0008), 5'd5,  32'h0001_1233, 4'd4}, // R4 reads stored word
        '{enc_i(6'h0D, 5'd0, 5'd6, 16'h000C), 5'd6,  32'h0000_000C, 4'd3}, // R3
        '{enc_i(6'h23, 5'd6, 5'd7, 16'hFFFC), 5'd7,  32'h0001_1233, 4'd4}, // R4 negative offset
        '{enc_r(5'd1, 5'd1, 5'd0, 6'h20),     5'd0,  32'h0000_0000, 4'd8}, // R8
        '{enc_r(5'd1, 5'd1, 5'd8, 6'h24),     5'd8,  32'h0000_0000, 4'd9}, // R9 bad funct
        '{enc_i(6'h3F, 5'd1, 5'd9, 16'h0055), 5'd9,  32'h0000_0000, 4'd9}, // R9 bad opcode
        '{enc_i(6'h23, 5'd0, 5'd10, 16'h0004),5'd10, 32'hCAFE_F00D, 4'd10},// R10 preloaded data
        '{enc_i(6'h04, 5'd1, 5'd2, 16'h0005), 5'd1,  32'h0000_1234, 4'd6}  // R6 not taken
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_word(input logic sel, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        load_en = 1'b1; load_sel = sel; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        for (int k = 0; k < NV; k++) load_word(1'b0, 6'(k), TBL[k].ins);
        load_word(1'b0, 6'd13, enc_i(6'h04, 5'd5, 5'd3, 16'h0002));
        load_word(1'b0, 6'd16, enc_j(26'd40));
        load_word(1'b0, 6'd40, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));
        load_word(1'b1, 6'd1, 32'hCAFE_F00D);
        load_word(1'b1, 6'd2, 32'h0000_0000);

        // R1 reset state
        dbg_idx = 5'd1; #1;
        check("R1 pc after reset", pc, 32'd0);
        check("R1 r1 after reset", dbg_data, 32'd0);

        @(negedge clk); rst = 1'b0;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            dbg_idx = TBL[k].rsel; #1;
            check($sformatf("R%0d step %0d reg", TBL[k].req, k), dbg_data, TBL[k].val);
            check($sformatf("R%0d step %0d pc", TBL[k].req, k), pc, 32'(4 * (k + 1)));
        end

        // R6 taken branch at 52 -> 64
        @(negedge clk); #1;
        check("R6 taken branch pc", pc, 32'd64);

        // R10 pause while loading, core sits on the jump
        load_en = 1'b1; load_sel = 1'b1; load_addr = 6'd3; load_data = 32'h5A5A_0003;
        @(negedge clk); #1;
        check("R10 pc held while loading", pc, 32'd64);
        load_addr = 6'd4;
        @(negedge clk); #1;
        check("R10 pc held second cycle", pc, 32'd64);
        load_en = 1'b0;

        // R7 jump
        @(negedge clk); #1;
        check("R7 jump pc", pc, 32'd160);
        // R6 backward branch onto itself
        @(negedge clk); #1;
        check("R6 backward branch pc", pc, 32'd160);

        // R11 debug read with no clock edge between index changes
        dbg_idx = 5'd3; #0.5;
        check("R11 debug r3", dbg_data, 32'h0001_1233);
        dbg_idx = 5'd4; #0.5;
        check("R11 debug r4", dbg_data, 32'hFFFF_1235);

        // R1 reset during a run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); dbg_idx = 5'd3; #1;
        check("R1 pc after mid-run reset", pc, 32'd0);
        check("R1 r3 after mid-run reset", dbg_data, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule